// File: doc/BRIEF.md
# Subcarrier Manchester response decoder

This block turns the card-to-reader half of a contactless exchange into bytes. An upstream detector delivers one group of four subcarrier samples for each half bit period, flagged by `grp_valid`. The decoder first hunts for a burst of modulation long enough to be a start of frame. It then pairs successive groups into bit periods and sorts each period as modulated in the first half only, the second half only, both halves or neither. Within a group, only one sample position, the sync position, is used for that judgement.

A start of frame has three periods: one with both halves modulated, then two with only the second half modulated. After that, a second-half-only period is a logic 1 and a first-half-only period is a logic 0. Bits arrive least significant first. Each completed byte is output with a one-cycle strobe, and its odd parity bit is shifted into a parity vector. A period with both halves modulated closes the frame. A partial last byte of two or more bits is output right-aligned. A silent period directly after the start of frame is a complete frame carrying the single byte 0x0F.

Every malformed frame leads to an error-wait period, after which the decoder hunts for sync again. The `abort` input lets the reader side cancel a false sync at any time.

Top module: `msx_resp_decoder`

## Requirements
- R1: After a synchronous active-low reset, `byte_valid`, `frame_done` and `parity_vec` are all 0 and the decoder is hunting for sync.
- R2: Sync is taken only when two consecutive valid groups share at least one set sample bit. The sync position is the highest shared bit, and this pair of groups counts as the first, both-halves period of the start of frame. Modulation spread over groups that share no bit never syncs and produces no output.
- R3: After sync, the next two periods must each be second-half-only (group pair 0 then modulated). Any other class makes the decoder enter the error wait and produce no byte or frame_done.
- R4: After the start of frame, a second-half-only period (0 then modulated) is bit 1 and a first-half-only period (modulated then 0) is bit 0. Bits fill a byte least significant bit first. After 8 bits the byte is output with a one-cycle `byte_valid`.
- R5: For each full byte, its odd parity bit (1 when the byte has an even count of ones) is shifted into bit 0 of `parity_vec`, and older bits move up. `parity_vec` is cleared when sync is taken.
- R6: A both-halves period after at least one collected bit or byte ends the frame with a one-cycle `frame_done`. If two or more bits of a partial byte are held, they are output right-aligned as one more byte, and a 0 is shifted into `parity_vec`. A single held bit is dropped.
- R7: A period with no modulation directly after the start of frame ends the frame with the single byte 0x0F, parity bit 1 and `frame_done`.
- R8: A period with no modulation after data bits is an error: no `frame_done` follows. Bytes already output stay output.
- R9: A both-halves period directly after the start of frame, with nothing collected, is an error with no byte and no `frame_done`.
- R10: The error wait lasts exactly one bit period (two valid groups), and then the decoder hunts for sync. A frame starting right after that period is decoded in full.
- R11: `abort` forces the decoder back to hunting on the next cycle. Bits collected before it are discarded, so the next frame's bytes are unaffected.
- R12: Cycles with `grp_valid` low change no decoder state, so gaps between groups do not alter the result.
- R13: After sync, only the sync position of each group decides modulation. With sync taken on bit 2, a period whose groups set only bit 1 counts as unmodulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Force the decoder back to sync hunting |
| grp_valid | input | 1 | A new half-period sample group is present |
| grp_data | input | GRP_W | Sample group, one bit per subcarrier sample |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a decoded byte |
| byte_data | output | DATA_W | Decoded byte, first received bit in bit 0 |
| parity_vec | output | PAR_W | Parity bits of the current frame, newest in bit 0 |
| frame_done | output | 1 | One-cycle strobe: the frame ended cleanly |

## Verification
Frames are built from period classes and carry bytes with mixed bit patterns. Two bytes of different parity show the bit polarity and bit order. Partial endings of three bits and of one bit separate right-alignment from dropping a single bit. Malformed starts, a silent period in the middle of data and an empty ending each distinguish an error from a clean end, and each is followed by a frame that must decode after exactly one wait period. Groups whose sample bits do not overlap test the sync rule. Groups with only the non-sync bit set show that a single sample position decides modulation. A mid-frame abort and frames with idle gaps between groups complete the set.

// File: rtl/msx_pkg.sv
// Shared types for the subcarrier Manchester response decoder.
package msx_pkg;

    // Decoder sequencing states.
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_SOF2  = 3'd1,
        ST_SOF3  = 3'd2,
        ST_SOFOK = 3'd3,
        ST_DATA  = 3'd4,
        ST_EWAIT = 3'd5
    } msx_state_t;

    // Bit period class, encoded as {first half modulated, second half modulated}.
    typedef enum logic [1:0] {
        PC_NONE   = 2'b00,
        PC_SECOND = 2'b01,
        PC_FIRST  = 2'b10,
        PC_BOTH   = 2'b11
    } msx_period_t;

endpackage

// File: rtl/msx_sync_hunt.sv
// Sync hunter: reports when two consecutive valid groups share a set sample
// bit and gives the highest shared bit as the sync position.
// Assumes: 'hunting' is high only while the decoder looks for sync; the
// stored group is cleared while not hunting, so stale samples never count.
module msx_sync_hunt #(
    parameter int GRP_W = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hunting,
    input  logic             grp_valid,
    input  logic [GRP_W-1:0] grp_data,
    output logic             found,
    output logic [SEL_W-1:0] sel
);

    logic [GRP_W-1:0] prev_grp;
    logic [GRP_W-1:0] common;

    // Keep the previous valid group while hunting.
    always_ff @(posedge clk) begin
        if (!rst_n)          prev_grp <= '0;
        else if (!hunting)   prev_grp <= '0;
        else if (grp_valid)  prev_grp <= grp_data;
    end

    // Detect overlap and pick the highest overlapping position.
    always_comb begin
        common = prev_grp & grp_data;
        found  = hunting && grp_valid && (|common);
        sel    = '0;
        for (int i = 0; i < GRP_W; i++) begin
            if (common[i]) sel = SEL_W'(i);
        end
    end

endmodule

// File: rtl/msx_half_sorter.sv
// Half-period sorter: pairs valid modulation flags into bit periods and
// classifies each period by which halves carried modulation.
// Assumes: 'restart' aligns the next valid group to a first half.
module msx_half_sorter
    import msx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        grp_valid,
    input  logic        mod,
    output logic        period_done,
    output msx_period_t period_cls
);

    logic second_half;
    logic first_mod;

    // Track which half comes next and hold the first half's flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_half <= 1'b0;
            first_mod   <= 1'b0;
        end else if (restart) begin
            second_half <= 1'b0;
        end else if (grp_valid) begin
            if (!second_half) first_mod <= mod;
            second_half <= ~second_half;
        end
    end

    // A period completes on the valid group of its second half.
    always_comb begin
        period_done = grp_valid && second_half && !restart;
        period_cls  = msx_period_t'({first_mod, mod});
    end

endmodule

// File: rtl/msx_byte_asm.sv
// Byte assembler: shifts bits in from the top, least significant bit first,
// outputs full bytes with odd parity, right-aligns a partial final byte of
// two or more bits, and can output a fixed byte for an empty frame.
// Assumes: at most one of clr, emit_fixed, push, finish per cycle (priority
// in that order); PAR_W is at least 2.
module msx_byte_asm #(
    parameter int          DATA_W     = 8,
    parameter int          PAR_W      = 32,
    parameter logic [DATA_W-1:0] EMPTY_BYTE = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              emit_fixed,
    input  logic              push,
    input  logic              push_bit,
    input  logic              finish,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [PAR_W-1:0]  parity_vec,
    output logic              has_data
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shreg_nxt;
    logic [CNT_W-1:0]  nbits;
    logic [CNT_W-1:0]  rshift;
    logic              got_byte;

    // Next shift value and the right-align distance for a partial byte.
    always_comb begin
        shreg_nxt = {push_bit, shreg[DATA_W-1:1]};
        rshift    = CNT_W'(DATA_W) - nbits;
        has_data  = got_byte || (nbits != '0);
    end

    // Collect bits, output bytes and keep the parity vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            nbits      <= '0;
            got_byte   <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            parity_vec <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clr) begin
                shreg      <= '0;
                nbits      <= '0;
                got_byte   <= 1'b0;
                parity_vec <= '0;
            end else if (emit_fixed) begin
                byte_valid <= 1'b1;
                byte_data  <= EMPTY_BYTE;
                parity_vec <= {parity_vec[PAR_W-2:0], ~^EMPTY_BYTE};
                got_byte   <= 1'b1;
            end else if (push) begin
                if (nbits == CNT_W'(DATA_W - 1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= shreg_nxt;
                    parity_vec <= {parity_vec[PAR_W-2:0], ~^shreg_nxt};
                    got_byte   <= 1'b1;
                    shreg      <= '0;
                    nbits      <= '0;
                end else begin
                    shreg <= shreg_nxt;
                    nbits <= nbits + 1'b1;
                end
            end else if (finish) begin
                if (nbits > CNT_W'(1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= shreg >> rshift;
                    parity_vec <= {parity_vec[PAR_W-2:0], 1'b0};
                end
                shreg <= '0;
                nbits <= '0;
            end
        end
    end

endmodule

// File: rtl/msx_resp_decoder.sv
// Subcarrier Manchester response decoder top: hunts for sync, checks the
// three-period start of frame, decodes data periods into bits and sequences
// end of frame, empty frames and the one-period error wait.
// Assumes: one sample group per half bit period on grp_valid; abort may
// arrive at any cycle and takes priority over everything else.
module msx_resp_decoder
    import msx_pkg::*;
#(
    parameter int GRP_W  = 4,
    parameter int DATA_W = 8,
    parameter int PAR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              grp_valid,
    input  logic [GRP_W-1:0]  grp_data,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [PAR_W-1:0]  parity_vec,
    output logic              frame_done
);

    localparam int SEL_W = (GRP_W > 1) ? $clog2(GRP_W) : 1;

    msx_state_t       state, state_nxt;
    logic [SEL_W-1:0] sync_sel;
    logic [SEL_W-1:0] hunt_sel;
    logic             hunt_found;
    logic             mod;
    logic             restart;
    logic             period_done;
    msx_period_t      period_cls;
    logic             clr, emit_fixed, push, push_bit, finish, has_data;
    logic             done_nxt;

    // Modulation is judged at the sync position only.
    always_comb begin
        mod     = grp_data[sync_sel];
        restart = (state == ST_HUNT) || abort;
    end

    msx_sync_hunt #(.GRP_W(GRP_W), .SEL_W(SEL_W)) u_hunt (
        .clk(clk), .rst_n(rst_n), .hunting(state == ST_HUNT),
        .grp_valid(grp_valid), .grp_data(grp_data),
        .found(hunt_found), .sel(hunt_sel)
    );

    msx_half_sorter u_sort (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .grp_valid(grp_valid), .mod(mod),
        .period_done(period_done), .period_cls(period_cls)
    );

    msx_byte_asm #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .emit_fixed(emit_fixed),
        .push(push), .push_bit(push_bit), .finish(finish),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .parity_vec(parity_vec), .has_data(has_data)
    );

    // Frame sequencing from completed period classes.
    always_comb begin
        state_nxt  = state;
        clr        = 1'b0;
        emit_fixed = 1'b0;
        push       = 1'b0;
        push_bit   = 1'b0;
        finish     = 1'b0;
        done_nxt   = 1'b0;
        if (abort) begin
            state_nxt = ST_HUNT;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (hunt_found) begin
                        state_nxt = ST_SOF2;
                        clr       = 1'b1;
                    end
                end
                ST_SOF2: begin
                    if (period_done)
                        state_nxt = (period_cls == PC_SECOND) ? ST_SOF3 : ST_EWAIT;
                end
                ST_SOF3: begin
                    if (period_done)
                        state_nxt = (period_cls == PC_SECOND) ? ST_SOFOK : ST_EWAIT;
                end
                ST_SOFOK, ST_DATA: begin
                    if (period_done) begin
                        case (period_cls)
                            PC_SECOND: begin
                                push      = 1'b1;
                                push_bit  = 1'b1;
                                state_nxt = ST_DATA;
                            end
                            PC_FIRST: begin
                                push      = 1'b1;
                                state_nxt = ST_DATA;
                            end
                            PC_BOTH: begin
                                if (has_data) begin
                                    finish    = 1'b1;
                                    done_nxt  = 1'b1;
                                    state_nxt = ST_HUNT;
                                end else begin
                                    state_nxt = ST_EWAIT;
                                end
                            end
                            default: begin
                                if (state == ST_SOFOK) begin
                                    emit_fixed = 1'b1;
                                    done_nxt   = 1'b1;
                                    state_nxt  = ST_HUNT;
                                end else begin
                                    state_nxt = ST_EWAIT;
                                end
                            end
                        endcase
                    end
                end
                ST_EWAIT: begin
                    if (period_done) state_nxt = ST_HUNT;
                end
                default: state_nxt = ST_HUNT;
            endcase
        end
    end

    // State, sync position and frame-done strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            sync_sel   <= '0;
            frame_done <= 1'b0;
        end else begin
            state      <= state_nxt;
            frame_done <= done_nxt;
            if (state == ST_HUNT && hunt_found && !abort) sync_sel <= hunt_sel;
        end
    end

endmodule

// File: rtl/msx_resp_checker.sv
// Assertion checker for the response decoder, attached by bind.
// Assumes: state is the decoder's sequencing register.
module msx_resp_checker
    import msx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       abort,
    input logic       grp_valid,
    input msx_state_t state,
    input logic       byte_valid,
    input logic       frame_done
);

    assert_abort_hunt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_HUNT));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_valid && !abort) |=> $stable(state));

    assert_done_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(state) == ST_SOFOK || $past(state) == ST_DATA));

    assert_byte_after_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ($past(state) == ST_SOFOK || $past(state) == ST_DATA));

    assert_wait_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EWAIT) |=> (state == ST_EWAIT || state == ST_HUNT));

    assert_sof_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOF3) |-> ($past(state) == ST_SOF2 || $past(state) == ST_SOF3));

endmodule

bind msx_resp_decoder msx_resp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .abort(abort), .grp_valid(grp_valid),
    .state(state), .byte_valid(byte_valid), .frame_done(frame_done)
);

// File: tb/sim_msx_resp_decoder.sv
`timescale 1ns/1ps
// Directed bench for the response decoder: one task per scenario.
module sim_msx_resp_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        grp_valid = 1'b0;
    logic [3:0]  grp_data = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [31:0] parity_vec;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    int gap = 0;
    logic [3:0] mask = 4'b1000;
    logic [7:0] log_b [0:63];
    int nlog = 0;
    int ndone = 0;

    always #2.5 clk = ~clk;

    msx_resp_decoder u0 (
        .clk(clk), .rst_n(rst_n), .abort(abort), .grp_valid(grp_valid),
        .grp_data(grp_data), .byte_valid(byte_valid), .byte_data(byte_data),
        .parity_vec(parity_vec), .frame_done(frame_done)
    );

    // Record output strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid && nlog < 64) begin
                log_b[nlog] = byte_data;
                nlog = nlog + 1;
            end
            if (frame_done) ndone = ndone + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nlog = 0;
        ndone = 0;
    endtask

    task automatic grp(input logic [3:0] g);
        @(negedge clk);
        grp_valid = 1'b1;
        grp_data  = g;
        @(negedge clk);
        grp_valid = 1'b0;
        grp_data  = '0;
        repeat (gap) @(negedge clk);
    endtask

    // Period class as {first half, second half}.
    task automatic per(input logic [1:0] c);
        grp(c[1] ? mask : 4'b0000);
        grp(c[0] ? mask : 4'b0000);
    endtask

    task automatic sof();
        per(2'b11); per(2'b01); per(2'b01);
    endtask

    task automatic put_bit(input logic b);
        per(b ? 2'b01 : 2'b10);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) put_bit(b[i]);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 byte_valid", byte_valid, 0);
        check("R1 frame_done", frame_done, 0);
        check("R1 parity_vec", parity_vec, 0);
    endtask

    task automatic t_two_bytes();
        clear_log();
        sof(); put_byte(8'hA5); put_byte(8'h01); per(2'b11); settle();
        check("R4 byte count", nlog, 2);
        check("R4 first byte", log_b[0], 8'hA5);
        check("R4 second byte", log_b[1], 8'h01);
        check("R5 parity vector", parity_vec, 2);
        check("R6 frame_done", ndone, 1);
    endtask

    task automatic t_partial();
        clear_log();
        sof(); put_byte(8'h3C); put_bit(1); put_bit(1); put_bit(0); per(2'b11); settle();
        check("R6 partial count", nlog, 2);
        check("R6 partial value", log_b[1], 3);
        check("R6 partial parity", parity_vec, 2);
        check("R6 partial done", ndone, 1);
    endtask

    task automatic t_one_bit();
        clear_log();
        sof(); put_byte(8'h5A); put_bit(1); per(2'b11); settle();
        check("R6 single bit dropped", nlog, 1);
        check("R6 single bit parity", parity_vec, 1);
        check("R6 single bit done", ndone, 1);
    endtask

    task automatic t_empty();
        clear_log();
        sof(); per(2'b00); settle();
        check("R7 count", nlog, 1);
        check("R7 value", log_b[0], 8'h0F);
        check("R7 parity", parity_vec, 1);
        check("R7 done", ndone, 1);
    endtask

    task automatic t_no_overlap();
        clear_log();
        grp(4'b1000); grp(4'b0100); grp(4'b0000); grp(4'b1000);
        grp(4'b0000); grp(4'b0010); grp(4'b0000); grp(4'b0000); settle();
        check("R2 no sync bytes", nlog, 0);
        check("R2 no sync done", ndone, 0);
    endtask

    task automatic t_bad_sof();
        clear_log();
        per(2'b11); per(2'b10); settle();
        check("R3 bad sof bytes", nlog, 0);
        check("R3 bad sof done", ndone, 0);
        per(2'b00);
        sof(); put_byte(8'h96); per(2'b11); settle();
        check("R10 recovered count", nlog, 1);
        check("R10 recovered byte", log_b[0], 8'h96);
        check("R10 recovered done", ndone, 1);
    endtask

    task automatic t_silent_mid();
        clear_log();
        sof(); put_byte(8'h11); put_bit(1); per(2'b00); settle();
        check("R8 byte kept", nlog, 1);
        check("R8 no done", ndone, 0);
        per(2'b00);
    endtask

    task automatic t_empty_end();
        clear_log();
        sof(); per(2'b11); settle();
        check("R9 no bytes", nlog, 0);
        check("R9 no done", ndone, 0);
        per(2'b00);
    endtask

    task automatic t_abort();
        clear_log();
        sof(); put_bit(1); put_bit(0); put_bit(1);
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        sof(); put_byte(8'hC3); per(2'b11); settle();
        check("R11 count", nlog, 1);
        check("R11 byte", log_b[0], 8'hC3);
        check("R11 done", ndone, 1);
    endtask

    task automatic t_sync_pos();
        clear_log();
        mask = 4'b0110; per(2'b11);
        mask = 4'b0100; per(2'b01); per(2'b01);
        mask = 4'b0010; per(2'b11); settle();
        check("R13 off-position ignored count", nlog, 1);
        check("R13 off-position ignored byte", log_b[0], 8'h0F);
        clear_log();
        mask = 4'b0110; per(2'b11);
        mask = 4'b0100; per(2'b01); per(2'b01); put_byte(8'h81); per(2'b11); settle();
        check("R13 sync position byte", log_b[0], 8'h81);
        check("R13 sync position done", ndone, 1);
        mask = 4'b1000;
    endtask

    task automatic t_gaps();
        clear_log();
        gap = 3;
        sof(); put_byte(8'h7E); per(2'b11);
        gap = 0;
        settle();
        check("R12 gapped byte", log_b[0], 8'h7E);
        check("R12 gapped count", nlog, 1);
        check("R12 gapped done", ndone, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_bytes();
        t_partial();
        t_one_bit();
        t_empty();
        t_no_overlap();
        t_bad_sof();
        t_silent_mid();
        t_empty_end();
        t_abort();
        t_sync_pos();
        t_gaps();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule